// File: doc/BRIEF.md
# Ring Redundancy Replicator and Fuser

This unit sits in a switch of a dual-direction ring and handles the redundancy of critical traffic at the level of frame descriptors (class, virtual link, sequence number). On the end-system side, it can turn each time-triggered (TT) or rate-constrained (RC) frame coming from a non-redundant end system into two identical copies, one for each ring direction. Best-effort (BE) frames are never duplicated.

On the ring side, it receives copies from two ring ports. If the attached destination has no redundancy of its own, fusion is enabled and the unit delivers one frame per virtual link. RC copies are kept or dropped by comparing their 16-bit sequence numbers with the last accepted number of the link. TT copies are held in a per-link buffer. A schedule strobe names the link whose send instant has come, and at that moment one held copy is issued. If no copy is held, an omission is recorded, and the send time is the same in both cases. If fusion is disabled, the destination is assumed to fuse internally, and every good copy is passed on unchanged.

Class encoding on every class field: 0 = BE, 1 = RC, 2 = TT, 3 = reserved and handled like BE. All outputs are registered, so each result appears one clock cycle after the inputs that caused it.

Top module: `rr_unit`

## Requirements
- R1: An end-system frame of class 0 or 3 leaves one cycle later on ring port 0 only (tx0_valid=1, tx1_valid=0), with class, link and sequence unchanged.
- R2: With rep_en=1, an end-system frame of class 1 or 2 leaves one cycle later on both ring ports in the same cycle with identical fields. With rep_en=0, it leaves on port 0 only.
- R3: A ring copy with rx_ok=0 is never delivered and does not change any fusion state, so a later good copy with the same sequence number is still accepted.
- R4: With fuse_en=0, every good ring copy of any class is delivered one cycle later on the lane of its own port (dl0 for port 0, dl1 for port 1).
- R5: With fuse_en=1, an RC copy is delivered only if it is the first copy on its link since reset, or if (seq - last) mod 65536 is in 1..32767, where last is the last accepted number of that link. Any other RC copy is dropped.
- R6: With fuse_en=1, if both ports present RC copies of the same link and the same new sequence number in one cycle, only lane dl0 delivers it.
- R7: With fuse_en=1, TT copies are not delivered on the dl lanes but are held per link. One cycle after tt_fire for a link that holds a copy, tt_valid=1 with that link and the sequence number of the port 0 copy if one is held, otherwise the port 1 copy. tt_src names the port, and the link's buffer is emptied.
- R8: One cycle after tt_fire for a link that holds no copy, tt_miss=1 and tt_valid=0. That link's omission count is incremented (saturating at its maximum), and the new count is shown on tt_miss_cnt.
- R9: A TT copy that arrives in the same cycle as tt_fire for its link is not seen by that send instant. It is kept for the next one.
- R10: With fuse_en=1, good BE copies from either ring port are delivered on their own lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rep_en | input | 1 | Enables duplication of RC/TT end-system frames |
| fuse_en | input | 1 | Enables fusion of ring copies |
| es_valid | input | 1 | End-system frame present |
| es_class | input | 2 | End-system frame class |
| es_vl | input | VL_W | End-system frame virtual link |
| es_seq | input | SEQ_W | End-system frame sequence number |
| tx0_valid | output | 1 | Frame issued on ring port 0 |
| tx1_valid | output | 1 | Frame issued on ring port 1 |
| tx_class | output | 2 | Class of the issued frame |
| tx_vl | output | VL_W | Link of the issued frame |
| tx_seq | output | SEQ_W | Sequence number of the issued frame |
| rx0_valid | input | 1 | Copy present on ring port 0 |
| rx0_ok | input | 1 | Port 0 copy passed the integrity check |
| rx0_class | input | 2 | Port 0 copy class |
| rx0_vl | input | VL_W | Port 0 copy link |
| rx0_seq | input | SEQ_W | Port 0 copy sequence number |
| rx1_valid | input | 1 | Copy present on ring port 1 |
| rx1_ok | input | 1 | Port 1 copy passed the integrity check |
| rx1_class | input | 2 | Port 1 copy class |
| rx1_vl | input | VL_W | Port 1 copy link |
| rx1_seq | input | SEQ_W | Port 1 copy sequence number |
| dl0_valid | output | 1 | Delivery lane 0 frame |
| dl0_class | output | 2 | Lane 0 class |
| dl0_vl | output | VL_W | Lane 0 link |
| dl0_seq | output | SEQ_W | Lane 0 sequence number |
| dl1_valid | output | 1 | Delivery lane 1 frame |
| dl1_class | output | 2 | Lane 1 class |
| dl1_vl | output | VL_W | Lane 1 link |
| dl1_seq | output | SEQ_W | Lane 1 sequence number |
| tt_fire | input | 1 | Send instant strobe |
| tt_fire_vl | input | VL_W | Link whose send instant it is |
| tt_valid | output | 1 | Fused TT frame issued |
| tt_vl | output | VL_W | Link of the TT result |
| tt_seq | output | SEQ_W | Sequence number of the issued TT copy |
| tt_src | output | 1 | Ring port the issued TT copy came from |
| tt_miss | output | 1 | Send instant found no copy |
| tt_miss_cnt | output | MISS_W | Omission count of the link after this instant |

## Verification
Two functions can meet in one cycle. A TT copy for a link can arrive in the same cycle as that link's send instant. Separately, both ring ports can present RC copies of the same link at once. The bench provokes the first by raising tt_fire together with a port 0 TT copy for the same link while the buffer is empty. It expects an omission with count 1, and on the following instant it expects the copy to be issued from port 0. It provokes the second by offering equal and then unequal sequence numbers on the two ports in one cycle. It expects a single delivery on lane 0 for equal numbers and both deliveries for different links.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [1:0] {
        CL_BE  = 2'd0,
        CL_RC  = 2'd1,
        CL_TT  = 2'd2,
        CL_RSV = 2'd3
    } cls_e;

    function automatic logic is_crit(input logic [1:0] c);
        return (c == CL_RC) || (c == CL_TT);
    endfunction
endpackage

// File: rtl/rr_replicator.sv
module rr_replicator
    import rr_pkg::*;
#(
    parameter int VL_W  = 3,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rep_en,
    input  logic             es_valid,
    input  logic [1:0]       es_class,
    input  logic [VL_W-1:0]  es_vl,
    input  logic [SEQ_W-1:0] es_seq,
    output logic             tx0_valid,
    output logic             tx1_valid,
    output logic [1:0]       tx_class,
    output logic [VL_W-1:0]  tx_vl,
    output logic [SEQ_W-1:0] tx_seq
);
    typedef struct packed {
        logic             v0;
        logic             v1;
        logic [1:0]       cls;
        logic [VL_W-1:0]  vl;
        logic [SEQ_W-1:0] seq;
    } rep_t;

    rep_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.v0  = es_valid;
        s_d.v1  = es_valid && rep_en && is_crit(es_class);
        if (es_valid) begin
            s_d.cls = es_class;
            s_d.vl  = es_vl;
            s_d.seq = es_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx0_valid = s_q.v0;
    assign tx1_valid = s_q.v1;
    assign tx_class  = s_q.cls;
    assign tx_vl     = s_q.vl;
    assign tx_seq    = s_q.seq;
endmodule

// File: rtl/rr_fuse_path.sv
module rr_fuse_path
    import rr_pkg::*;
#(
    parameter int NUM_VL = 8,
    parameter int VL_W   = 3,
    parameter int SEQ_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_en,
    input  logic             rx0_valid,
    input  logic             rx0_ok,
    input  logic [1:0]       rx0_class,
    input  logic [VL_W-1:0]  rx0_vl,
    input  logic [SEQ_W-1:0] rx0_seq,
    input  logic             rx1_valid,
    input  logic             rx1_ok,
    input  logic [1:0]       rx1_class,
    input  logic [VL_W-1:0]  rx1_vl,
    input  logic [SEQ_W-1:0] rx1_seq,
    output logic             dl0_valid,
    output logic [1:0]       dl0_class,
    output logic [VL_W-1:0]  dl0_vl,
    output logic [SEQ_W-1:0] dl0_seq,
    output logic             dl1_valid,
    output logic [1:0]       dl1_class,
    output logic [VL_W-1:0]  dl1_vl,
    output logic [SEQ_W-1:0] dl1_seq
);
    typedef struct packed {
        logic             v;
        logic [1:0]       cls;
        logic [VL_W-1:0]  vl;
        logic [SEQ_W-1:0] seq;
    } lane_t;

    typedef struct packed {
        logic [NUM_VL-1:0][SEQ_W-1:0] last;
        logic [NUM_VL-1:0]            seen;
        lane_t                        ln0;
        lane_t                        ln1;
    } fp_t;

    fp_t s_d, s_q;

    // Forward distance check on a modular sequence space
    function automatic logic ahead(input logic [SEQ_W-1:0] nw, input logic [SEQ_W-1:0] old);
        logic [SEQ_W-1:0] df;
        df = nw - old;
        return (df != '0) && !df[SEQ_W-1];
    endfunction

    // Lane admission: pass all when unfused; drop TT, filter RC when fused
    function automatic logic admit(input logic en, input logic [1:0] c, input logic rc_ok);
        if (!en)            return 1'b1;
        else if (c == CL_TT) return 1'b0;
        else if (c == CL_RC) return rc_ok;
        else                return 1'b1;
    endfunction

    logic             good0, good1;
    logic             acc0, acc1;
    logic             same_vl;
    logic [SEQ_W-1:0] base1;
    logic             seen1;

    always_comb begin
        good0   = rx0_valid && rx0_ok;
        good1   = rx1_valid && rx1_ok;
        acc0    = good0 && (rx0_class == CL_RC)
                  && (!s_q.seen[rx0_vl] || ahead(rx0_seq, s_q.last[rx0_vl]));
        // Port 1 is judged after port 0 within the same cycle
        same_vl = acc0 && (rx1_vl == rx0_vl);
        base1   = same_vl ? rx0_seq : s_q.last[rx1_vl];
        seen1   = same_vl || s_q.seen[rx1_vl];
        acc1    = good1 && (rx1_class == CL_RC) && (!seen1 || ahead(rx1_seq, base1));

        s_d = s_q;
        if (fuse_en && acc0) begin
            s_d.seen[rx0_vl] = 1'b1;
            s_d.last[rx0_vl] = rx0_seq;
        end
        if (fuse_en && acc1) begin
            s_d.seen[rx1_vl] = 1'b1;
            s_d.last[rx1_vl] = rx1_seq;
        end

        s_d.ln0.v = good0 && admit(fuse_en, rx0_class, acc0);
        s_d.ln1.v = good1 && admit(fuse_en, rx1_class, acc1);
        if (good0) begin
            s_d.ln0.cls = rx0_class;
            s_d.ln0.vl  = rx0_vl;
            s_d.ln0.seq = rx0_seq;
        end
        if (good1) begin
            s_d.ln1.cls = rx1_class;
            s_d.ln1.vl  = rx1_vl;
            s_d.ln1.seq = rx1_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dl0_valid = s_q.ln0.v;
    assign dl0_class = s_q.ln0.cls;
    assign dl0_vl    = s_q.ln0.vl;
    assign dl0_seq   = s_q.ln0.seq;
    assign dl1_valid = s_q.ln1.v;
    assign dl1_class = s_q.ln1.cls;
    assign dl1_vl    = s_q.ln1.vl;
    assign dl1_seq   = s_q.ln1.seq;
endmodule

// File: rtl/rr_tt_fuse.sv
module rr_tt_fuse
    import rr_pkg::*;
#(
    parameter int NUM_VL = 8,
    parameter int VL_W   = 3,
    parameter int SEQ_W  = 16,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_en,
    input  logic              rx0_valid,
    input  logic              rx0_ok,
    input  logic [1:0]        rx0_class,
    input  logic [VL_W-1:0]   rx0_vl,
    input  logic [SEQ_W-1:0]  rx0_seq,
    input  logic              rx1_valid,
    input  logic              rx1_ok,
    input  logic [1:0]        rx1_class,
    input  logic [VL_W-1:0]   rx1_vl,
    input  logic [SEQ_W-1:0]  rx1_seq,
    input  logic              tt_fire,
    input  logic [VL_W-1:0]   tt_fire_vl,
    output logic              tt_valid,
    output logic [VL_W-1:0]   tt_vl,
    output logic [SEQ_W-1:0]  tt_seq,
    output logic              tt_src,
    output logic              tt_miss,
    output logic [MISS_W-1:0] tt_miss_cnt
);
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    typedef struct packed {
        logic [NUM_VL-1:0]             pend0;
        logic [NUM_VL-1:0]             pend1;
        logic [NUM_VL-1:0][SEQ_W-1:0]  seq0;
        logic [NUM_VL-1:0][SEQ_W-1:0]  seq1;
        logic [NUM_VL-1:0][MISS_W-1:0] miss;
        logic                          ov;
        logic [VL_W-1:0]               ovl;
        logic [SEQ_W-1:0]              oseq;
        logic                          osrc;
        logic                          omiss;
        logic [MISS_W-1:0]             ocnt;
    } tt_t;

    tt_t s_d, s_q;

    logic arr0, arr1;

    always_comb begin
        arr0 = fuse_en && rx0_valid && rx0_ok && (rx0_class == CL_TT);
        arr1 = fuse_en && rx1_valid && rx1_ok && (rx1_class == CL_TT);

        s_d       = s_q;
        s_d.ov    = 1'b0;
        s_d.omiss = 1'b0;

        // Send instant works on the buffer as it stood before this cycle
        if (tt_fire) begin
            s_d.ovl = tt_fire_vl;
            if (s_q.pend0[tt_fire_vl]) begin
                s_d.ov   = 1'b1;
                s_d.osrc = 1'b0;
                s_d.oseq = s_q.seq0[tt_fire_vl];
            end else if (s_q.pend1[tt_fire_vl]) begin
                s_d.ov   = 1'b1;
                s_d.osrc = 1'b1;
                s_d.oseq = s_q.seq1[tt_fire_vl];
            end else begin
                s_d.omiss = 1'b1;
                if (s_q.miss[tt_fire_vl] != MISS_MAX)
                    s_d.miss[tt_fire_vl] = s_q.miss[tt_fire_vl] + 1'b1;
                s_d.ocnt = s_d.miss[tt_fire_vl];
            end
            s_d.pend0[tt_fire_vl] = 1'b0;
            s_d.pend1[tt_fire_vl] = 1'b0;
        end

        // Arrivals land after the instant's clear, kept for the next one
        if (arr0) begin
            s_d.pend0[rx0_vl] = 1'b1;
            s_d.seq0[rx0_vl]  = rx0_seq;
        end
        if (arr1) begin
            s_d.pend1[rx1_vl] = 1'b1;
            s_d.seq1[rx1_vl]  = rx1_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tt_valid    = s_q.ov;
    assign tt_vl       = s_q.ovl;
    assign tt_seq      = s_q.oseq;
    assign tt_src      = s_q.osrc;
    assign tt_miss     = s_q.omiss;
    assign tt_miss_cnt = s_q.ocnt;
endmodule

// File: rtl/rr_unit.sv
module rr_unit
    import rr_pkg::*;
#(
    parameter int NUM_VL = 8,
    parameter int SEQ_W  = 16,
    parameter int MISS_W = 8,
    localparam int VL_W  = (NUM_VL > 1) ? $clog2(NUM_VL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rep_en,
    input  logic              fuse_en,
    input  logic              es_valid,
    input  logic [1:0]        es_class,
    input  logic [VL_W-1:0]   es_vl,
    input  logic [SEQ_W-1:0]  es_seq,
    output logic              tx0_valid,
    output logic              tx1_valid,
    output logic [1:0]        tx_class,
    output logic [VL_W-1:0]   tx_vl,
    output logic [SEQ_W-1:0]  tx_seq,
    input  logic              rx0_valid,
    input  logic              rx0_ok,
    input  logic [1:0]        rx0_class,
    input  logic [VL_W-1:0]   rx0_vl,
    input  logic [SEQ_W-1:0]  rx0_seq,
    input  logic              rx1_valid,
    input  logic              rx1_ok,
    input  logic [1:0]        rx1_class,
    input  logic [VL_W-1:0]   rx1_vl,
    input  logic [SEQ_W-1:0]  rx1_seq,
    output logic              dl0_valid,
    output logic [1:0]        dl0_class,
    output logic [VL_W-1:0]   dl0_vl,
    output logic [SEQ_W-1:0]  dl0_seq,
    output logic              dl1_valid,
    output logic [1:0]        dl1_class,
    output logic [VL_W-1:0]   dl1_vl,
    output logic [SEQ_W-1:0]  dl1_seq,
    input  logic              tt_fire,
    input  logic [VL_W-1:0]   tt_fire_vl,
    output logic              tt_valid,
    output logic [VL_W-1:0]   tt_vl,
    output logic [SEQ_W-1:0]  tt_seq,
    output logic              tt_src,
    output logic              tt_miss,
    output logic [MISS_W-1:0] tt_miss_cnt
);
    rr_replicator #(.VL_W(VL_W), .SEQ_W(SEQ_W)) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .rep_en    (rep_en),
        .es_valid  (es_valid),
        .es_class  (es_class),
        .es_vl     (es_vl),
        .es_seq    (es_seq),
        .tx0_valid (tx0_valid),
        .tx1_valid (tx1_valid),
        .tx_class  (tx_class),
        .tx_vl     (tx_vl),
        .tx_seq    (tx_seq)
    );

    rr_fuse_path #(.NUM_VL(NUM_VL), .VL_W(VL_W), .SEQ_W(SEQ_W)) u_fp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fuse_en   (fuse_en),
        .rx0_valid (rx0_valid),
        .rx0_ok    (rx0_ok),
        .rx0_class (rx0_class),
        .rx0_vl    (rx0_vl),
        .rx0_seq   (rx0_seq),
        .rx1_valid (rx1_valid),
        .rx1_ok    (rx1_ok),
        .rx1_class (rx1_class),
        .rx1_vl    (rx1_vl),
        .rx1_seq   (rx1_seq),
        .dl0_valid (dl0_valid),
        .dl0_class (dl0_class),
        .dl0_vl    (dl0_vl),
        .dl0_seq   (dl0_seq),
        .dl1_valid (dl1_valid),
        .dl1_class (dl1_class),
        .dl1_vl    (dl1_vl),
        .dl1_seq   (dl1_seq)
    );

    rr_tt_fuse #(.NUM_VL(NUM_VL), .VL_W(VL_W), .SEQ_W(SEQ_W), .MISS_W(MISS_W)) u_tt (
        .clk         (clk),
        .rst_n       (rst_n),
        .fuse_en     (fuse_en),
        .rx0_valid   (rx0_valid),
        .rx0_ok      (rx0_ok),
        .rx0_class   (rx0_class),
        .rx0_vl      (rx0_vl),
        .rx0_seq     (rx0_seq),
        .rx1_valid   (rx1_valid),
        .rx1_ok      (rx1_ok),
        .rx1_class   (rx1_class),
        .rx1_vl      (rx1_vl),
        .rx1_seq     (rx1_seq),
        .tt_fire     (tt_fire),
        .tt_fire_vl  (tt_fire_vl),
        .tt_valid    (tt_valid),
        .tt_vl       (tt_vl),
        .tt_seq      (tt_seq),
        .tt_src      (tt_src),
        .tt_miss     (tt_miss),
        .tt_miss_cnt (tt_miss_cnt)
    );
endmodule

// File: rtl/rr_unit_chk.sv
module rr_unit_chk
    import rr_pkg::*;
#(
    parameter int VL_W   = 3,
    parameter int SEQ_W  = 16,
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fuse_en,
    input logic              tx0_valid,
    input logic              tx1_valid,
    input logic [1:0]        tx_class,
    input logic              dl0_valid,
    input logic [1:0]        dl0_class,
    input logic [VL_W-1:0]   dl0_vl,
    input logic [SEQ_W-1:0]  dl0_seq,
    input logic              dl1_valid,
    input logic [1:0]        dl1_class,
    input logic [VL_W-1:0]   dl1_vl,
    input logic [SEQ_W-1:0]  dl1_seq,
    input logic              tt_fire,
    input logic              tt_valid,
    input logic              tt_miss,
    input logic [MISS_W-1:0] tt_miss_cnt
);
    a_r2_copy_pair: assert property (@(posedge clk) disable iff (!rst_n)
        tx1_valid |-> (tx0_valid && is_crit(tx_class)));

    a_r1_be_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tx0_valid && !is_crit(tx_class)) |-> !tx1_valid);

    a_r6_one_rc_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fuse_en) && dl0_valid && dl1_valid && dl0_class == CL_RC
         && dl1_class == CL_RC && dl0_vl == dl1_vl) |-> (dl0_seq != dl1_seq));

    a_r7_tt_held0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fuse_en) && dl0_valid) |-> (dl0_class != CL_TT));

    a_r7_tt_held1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fuse_en) && dl1_valid) |-> (dl1_class != CL_TT));

    a_r7_instant_answer: assert property (@(posedge clk) disable iff (!rst_n)
        tt_fire |=> (tt_valid != tt_miss));

    a_r7_only_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (tt_valid || tt_miss) |-> $past(tt_fire));

    a_r8_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        tt_miss |-> (tt_miss_cnt != '0));
endmodule

bind rr_unit rr_unit_chk #(.VL_W(VL_W), .SEQ_W(SEQ_W), .MISS_W(MISS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fuse_en     (fuse_en),
    .tx0_valid   (tx0_valid),
    .tx1_valid   (tx1_valid),
    .tx_class    (tx_class),
    .dl0_valid   (dl0_valid),
    .dl0_class   (dl0_class),
    .dl0_vl      (dl0_vl),
    .dl0_seq     (dl0_seq),
    .dl1_valid   (dl1_valid),
    .dl1_class   (dl1_class),
    .dl1_vl      (dl1_vl),
    .dl1_seq     (dl1_seq),
    .tt_fire     (tt_fire),
    .tt_valid    (tt_valid),
    .tt_miss     (tt_miss),
    .tt_miss_cnt (tt_miss_cnt)
);

// File: tb/rr_unit_tb.sv
`timescale 1ns/1ps
module rr_unit_tb;
    localparam int NUM_VL = 8;
    localparam int SEQ_W  = 16;
    localparam int MISS_W = 8;
    localparam int VL_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rep_en = 1'b0, fuse_en = 1'b0;
    logic es_valid = 1'b0;
    logic [1:0] es_class = '0;
    logic [VL_W-1:0] es_vl = '0;
    logic [SEQ_W-1:0] es_seq = '0;
    logic tx0_valid, tx1_valid;
    logic [1:0] tx_class;
    logic [VL_W-1:0] tx_vl;
    logic [SEQ_W-1:0] tx_seq;
    logic rx0_valid = 1'b0, rx0_ok = 1'b0, rx1_valid = 1'b0, rx1_ok = 1'b0;
    logic [1:0] rx0_class = '0, rx1_class = '0;
    logic [VL_W-1:0] rx0_vl = '0, rx1_vl = '0;
    logic [SEQ_W-1:0] rx0_seq = '0, rx1_seq = '0;
    logic dl0_valid, dl1_valid;
    logic [1:0] dl0_class, dl1_class;
    logic [VL_W-1:0] dl0_vl, dl1_vl;
    logic [SEQ_W-1:0] dl0_seq, dl1_seq;
    logic tt_fire = 1'b0;
    logic [VL_W-1:0] tt_fire_vl = '0;
    logic tt_valid, tt_src, tt_miss;
    logic [VL_W-1:0] tt_vl;
    logic [SEQ_W-1:0] tt_seq;
    logic [MISS_W-1:0] tt_miss_cnt;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    rr_unit #(.NUM_VL(NUM_VL), .SEQ_W(SEQ_W), .MISS_W(MISS_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clr();
        es_valid = 1'b0; rx0_valid = 1'b0; rx1_valid = 1'b0; tt_fire = 1'b0;
    endtask

    task automatic put_rx0(input logic [1:0] c, input int vl, input int sq, input logic ok);
        rx0_valid = 1'b1; rx0_ok = ok; rx0_class = c;
        rx0_vl = VL_W'(vl); rx0_seq = SEQ_W'(sq);
    endtask

    task automatic put_rx1(input logic [1:0] c, input int vl, input int sq, input logic ok);
        rx1_valid = 1'b1; rx1_ok = ok; rx1_class = c;
        rx1_vl = VL_W'(vl); rx1_seq = SEQ_W'(sq);
    endtask

    task automatic put_es(input logic [1:0] c, input int vl, input int sq);
        es_valid = 1'b1; es_class = c; es_vl = VL_W'(vl); es_seq = SEQ_W'(sq);
    endtask

    task automatic fire(input int vl);
        tt_fire = 1'b1; tt_fire_vl = VL_W'(vl);
    endtask

    task automatic t_reset();
        chk("reset tx0", 32'(tx0_valid), 0);
        chk("reset tx1", 32'(tx1_valid), 0);
        chk("reset dl", 32'({dl0_valid, dl1_valid}), 0);
        chk("reset tt", 32'({tt_valid, tt_miss}), 0);
    endtask

    task automatic t_replicate();
        rep_en = 1'b1;
        put_es(2'd1, 5, 16'h1234); tick();
        chk("R2 rc both", 32'({tx0_valid, tx1_valid}), 32'b11);
        chk("R2 rc fields", 32'({tx_class, tx_vl, tx_seq}), 32'({2'd1, 3'd5, 16'h1234}));
        clr(); put_es(2'd2, 3, 16'h0042); tick();
        chk("R2 tt both", 32'({tx0_valid, tx1_valid}), 32'b11);
        chk("R2 tt seq", 32'(tx_seq), 32'h42);
        clr(); put_es(2'd0, 1, 16'h0007); tick();
        chk("R1 be single", 32'({tx0_valid, tx1_valid}), 32'b10);
        chk("R1 be fields", 32'({tx_class, tx_vl, tx_seq}), 32'({2'd0, 3'd1, 16'h0007}));
        clr(); put_es(2'd3, 2, 16'h0008); tick();
        chk("R1 rsv single", 32'({tx0_valid, tx1_valid}), 32'b10);
        clr(); rep_en = 1'b0; put_es(2'd1, 4, 16'h0009); tick();
        chk("R2 rep off", 32'({tx0_valid, tx1_valid}), 32'b10);
        clr(); tick();
        chk("R2 idle", 32'({tx0_valid, tx1_valid}), 32'b00);
    endtask

    task automatic t_rc_fuse();
        fuse_en = 1'b1;
        put_rx1(2'd1, 2, 100, 1'b1); tick();
        chk("R5 first accepted", 32'({dl0_valid, dl1_valid}), 32'b01);
        chk("R5 first seq", 32'(dl1_seq), 100);
        clr(); put_rx0(2'd1, 2, 100, 1'b1); tick();
        chk("R5 dup dropped", 32'({dl0_valid, dl1_valid}), 32'b00);
        clr(); put_rx0(2'd1, 2, 101, 1'b1); tick();
        chk("R5 next accepted", 32'({dl0_valid, dl1_valid}), 32'b10);
        clr(); put_rx1(2'd1, 2, 50, 1'b1); tick();
        chk("R5 stale dropped", 32'(dl1_valid), 0);
        clr(); put_rx0(2'd1, 3, 16'hFFFF, 1'b1); tick();
        chk("R5 vl3 first", 32'(dl0_valid), 1);
        clr(); put_rx0(2'd1, 3, 16'h0000, 1'b1); tick();
        chk("R5 wrap accepted", 32'(dl0_valid), 1);
        clr(); put_rx0(2'd1, 3, 16'h8000, 1'b1); tick();
        chk("R5 half range dropped", 32'(dl0_valid), 0);
        clr(); put_rx0(2'd1, 3, 16'h7FFF, 1'b1); tick();
        chk("R5 max ahead accepted", 32'(dl0_valid), 1);
        clr(); tick();
    endtask

    task automatic t_same_cycle();
        put_rx0(2'd1, 4, 7, 1'b1); put_rx1(2'd1, 4, 7, 1'b1); tick();
        chk("R6 single lane", 32'({dl0_valid, dl1_valid}), 32'b10);
        chk("R6 seq", 32'(dl0_seq), 7);
        clr(); put_rx0(2'd1, 0, 3, 1'b1); put_rx1(2'd1, 1, 4, 1'b1); tick();
        chk("R6 distinct links both", 32'({dl0_valid, dl1_valid}), 32'b11);
        clr(); put_rx0(2'd0, 6, 9, 1'b1); put_rx1(2'd0, 6, 9, 1'b1); tick();
        chk("R10 be both lanes", 32'({dl0_valid, dl1_valid}), 32'b11);
        clr(); tick();
    endtask

    task automatic t_corrupt();
        put_rx0(2'd1, 5, 9, 1'b0); tick();
        chk("R3 bad not delivered", 32'(dl0_valid), 0);
        clr(); put_rx1(2'd1, 5, 9, 1'b1); tick();
        chk("R3 good after bad", 32'(dl1_valid), 1);
        clr(); put_rx0(2'd2, 7, 1, 1'b0); tick(); clr(); fire(7); tick();
        chk("R3 bad tt not held", 32'({tt_valid, tt_miss}), 32'b01);
        clr(); tick();
    endtask

    task automatic t_unfused();
        fuse_en = 1'b0;
        put_rx0(2'd1, 2, 100, 1'b1); put_rx1(2'd1, 2, 100, 1'b1); tick();
        chk("R4 rc both lanes", 32'({dl0_valid, dl1_valid}), 32'b11);
        clr(); put_rx0(2'd2, 1, 5, 1'b1); put_rx1(2'd2, 1, 5, 1'b1); tick();
        chk("R4 tt both lanes", 32'({dl0_valid, dl1_valid}), 32'b11);
        chk("R4 tt class", 32'({dl0_class, dl1_class}), 32'({2'd2, 2'd2}));
        clr(); tick();
        fuse_en = 1'b1;
    endtask

    task automatic t_tt_fuse();
        put_rx1(2'd2, 1, 20, 1'b1); tick();
        chk("R7 tt not on lanes", 32'({dl0_valid, dl1_valid}), 32'b00);
        clr(); fire(1); tick();
        chk("R7 issue port1", 32'({tt_valid, tt_miss, tt_src}), 32'b101);
        chk("R7 seq", 32'({tt_vl, tt_seq}), 32'({3'd1, 16'd20}));
        clr(); put_rx0(2'd2, 6, 30, 1'b1); put_rx1(2'd2, 6, 31, 1'b1); tick();
        clr(); fire(6); tick();
        chk("R7 port0 preferred", 32'({tt_valid, tt_src}), 32'b10);
        chk("R7 port0 seq", 32'(tt_seq), 30);
        clr(); fire(6); tick();
        chk("R7 buffer emptied", 32'({tt_valid, tt_miss}), 32'b01);
        chk("R8 count vl6", 32'(tt_miss_cnt), 1);
        clr(); fire(7); tick();
        chk("R8 count vl7 first", 32'(tt_miss_cnt), 2);
        clr(); tick();
        chk("R8 pulse ends", 32'({tt_valid, tt_miss}), 32'b00);
        fire(7); tick();
        chk("R8 count vl7 second", 32'(tt_miss_cnt), 3);
        clr(); tick();
    endtask

    task automatic t_coincide();
        fire(1); put_rx0(2'd2, 1, 40, 1'b1); tick();
        chk("R9 arrival unseen", 32'({tt_valid, tt_miss}), 32'b01);
        chk("R9 count vl1", 32'(tt_miss_cnt), 1);
        clr(); fire(1); tick();
        chk("R9 kept for next", 32'({tt_valid, tt_src}), 32'b10);
        chk("R9 seq", 32'(tt_seq), 40);
        clr(); tick();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_replicate();
        t_rc_fuse();
        t_same_cycle();
        t_corrupt();
        t_unfused();
        t_tt_fuse();
        t_coincide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule